// File: doc/BRIEF.md
# Microcontroller Register File with Special Registers

This block is the data memory of a small 8-bit Harvard-style microcontroller core. It holds up to 64 byte-wide registers in one flat 6-bit address space. One write port takes the ALU result. Two combinational read ports supply the two ALU operands.

The three lowest addresses are special. Address 0 is the accumulator, which is also exported on a side port because the ALU uses it as an implicit operand. Address 1 is the status register. The ALU can update its zero and carry flags through a dedicated strobe, in parallel with normal writes. Address 2 is the program-counter-high register, and its low nibble is exported to the sequencer as the upper four bits of a 12-bit program address.

A parameter sets how many registers are actually built. It must be between 4 and 64. Addresses at or above that count hold nothing, so unused storage costs no area.

Top module: `banked_regfile`

## Requirements
- R1: An active-low asynchronous reset clears every built register to 0x00 at once. While reset is held, all outputs read zero.
- R2: When `wr_en_i` is high and `wr_addr_i` is below `NUM_REGS`, the addressed register takes `wr_data_i` at the rising clock edge. Reads are combinational, so a read of that address in the same cycle returns the old value.
- R3: A read of any address at or above `NUM_REGS` returns 0x00. A write to such an address changes no register.
- R4: Address 0 is the accumulator. `acc_o` always shows its current value.
- R5: Address 1 is the status register. If an explicit write to address 1 and the flag strobe occur in the same cycle, the explicit write sets all eight bits and the flag inputs are discarded.
- R6: If `flag_we_i` is high and address 1 is not being written, status bit 0 takes `flag_zero_i` and status bit 1 takes `flag_carry_i` at the clock edge. Status bits 7:2 keep their values.
- R7: Address 2 is the program-counter-high register. All 8 bits can be read back, and `pc_hi_o` always equals bits 3:0 of it.
- R8: The two read ports are independent. When both ports present the same address, they return the same data.
- R9: In a cycle with `wr_en_i` low and `flag_we_i` low, no register changes, whatever the address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable for the write port |
| wr_addr_i | input | 6 | Write address |
| wr_data_i | input | 8 | Write data (ALU result) |
| flag_we_i | input | 1 | Flag update strobe from the ALU |
| flag_zero_i | input | 1 | New zero flag (status bit 0) |
| flag_carry_i | input | 1 | New carry flag (status bit 1) |
| rd_a_addr_i | input | 6 | Read port A address |
| rd_a_data_o | output | 8 | Read port A data, combinational |
| rd_b_addr_i | input | 6 | Read port B address |
| rd_b_data_o | output | 8 | Read port B data, combinational |
| acc_o | output | 8 | Accumulator contents |
| status_o | output | 8 | Status register contents |
| pc_hi_o | output | 4 | Upper program-address bits from bits 3:0 of the program-counter-high register |

## Verification
Two status updates can fall in the same cycle: an explicit register write to address 1 and the ALU flag strobe. The bench provokes this by driving both with flag values that differ from the written byte. It judges the result by reading `status_o` in the next cycle, where the written byte must appear whole.

The bench also pairs the strobe alone with a status value that has its upper bits set, to show that bits 7:2 survive. A write and a read of the same address in one cycle are checked as well: the old value must appear first and the new value one cycle later.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 6;
  localparam int MAX_REGS  = 1 << ADDR_W;
  localparam int PC_HI_W   = 4;
  localparam int N_SPECIAL = 3;
  localparam int N_RD      = 2;

  // fixed special addresses
  localparam logic [ADDR_W-1:0] ACC_ADDR  = 6'd0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'd1;
  localparam logic [ADDR_W-1:0] PCH_ADDR  = 6'd2;

  // status flag positions
  localparam int STAT_Z_BIT = 0;
  localparam int STAT_C_BIT = 1;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                wr_en_i,
  input  addr_t               wr_addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  // one-hot select; addresses >= NUM_REGS select nothing
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign sel_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_special_regs.sv
module rf_special_regs
  import regfile_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_SPECIAL-1:0] sel_i,
  input  byte_t                wr_data_i,
  input  logic                 flag_we_i,
  input  logic                 flag_zero_i,
  input  logic                 flag_carry_i,
  output byte_t                acc_q_o,
  output byte_t                stat_q_o,
  output byte_t                pch_q_o
);
  byte_t acc_q, stat_q, pch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (sel_i[ACC_ADDR]) begin
      acc_q <= wr_data_i;
    end
  end

  // explicit write beats the flag strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (sel_i[STAT_ADDR]) begin
      stat_q <= wr_data_i;
    end else if (flag_we_i) begin
      stat_q[STAT_Z_BIT] <= flag_zero_i;
      stat_q[STAT_C_BIT] <= flag_carry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pch_q <= '0;
    end else if (sel_i[PCH_ADDR]) begin
      pch_q <= wr_data_i;
    end
  end

  assign acc_q_o  = acc_q;
  assign stat_q_o = stat_q;
  assign pch_q_o  = pch_q;
endmodule

// File: rtl/rf_gp_bank.sv
module rf_gp_bank
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_REGS-1:N_SPECIAL]         sel_i,
  input  byte_t                               wr_data_i,
  output logic [NUM_REGS-1:N_SPECIAL][DATA_W-1:0] gp_q_o
);
  for (genvar i = N_SPECIAL; i < NUM_REGS; i++) begin : g_reg
    byte_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (sel_i[i]) begin
        q <= wr_data_i;
      end
    end
    assign gp_q_o[i] = q;
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  addr_t                          addr_i,
  output byte_t                          data_o
);
  // unbuilt addresses fall through to zero
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) data_o = regs_i[i];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int NUM_REGS = 64  // 4 .. 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [5:0]   wr_addr_i,
  input  logic [7:0]   wr_data_i,
  input  logic         flag_we_i,
  input  logic         flag_zero_i,
  input  logic         flag_carry_i,
  input  logic [5:0]   rd_a_addr_i,
  output logic [7:0]   rd_a_data_o,
  input  logic [5:0]   rd_b_addr_i,
  output logic [7:0]   rd_b_data_o,
  output logic [7:0]   acc_o,
  output logic [7:0]   status_o,
  output logic [3:0]   pc_hi_o
);
  logic [NUM_REGS-1:0]                     wr_sel;
  byte_t                                   acc_q, stat_q, pch_q;
  logic [NUM_REGS-1:N_SPECIAL][DATA_W-1:0] gp_q;
  logic [NUM_REGS-1:0][DATA_W-1:0]         regs;
  addr_t                                   rd_addr [N_RD];
  byte_t                                   rd_data [N_RD];

  rf_wr_decode #(.NUM_REGS(NUM_REGS)) i_wr_decode (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .sel_o     (wr_sel)
  );

  rf_special_regs i_special (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (wr_sel[N_SPECIAL-1:0]),
    .wr_data_i    (wr_data_i),
    .flag_we_i    (flag_we_i),
    .flag_zero_i  (flag_zero_i),
    .flag_carry_i (flag_carry_i),
    .acc_q_o      (acc_q),
    .stat_q_o     (stat_q),
    .pch_q_o      (pch_q)
  );

  rf_gp_bank #(.NUM_REGS(NUM_REGS)) i_gp_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (wr_sel[NUM_REGS-1:N_SPECIAL]),
    .wr_data_i (wr_data_i),
    .gp_q_o    (gp_q)
  );

  // flat view of the address space
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_map
    if (i == int'(ACC_ADDR)) begin : g_acc
      assign regs[i] = acc_q;
    end else if (i == int'(STAT_ADDR)) begin : g_stat
      assign regs[i] = stat_q;
    end else if (i == int'(PCH_ADDR)) begin : g_pch
      assign regs[i] = pch_q;
    end else begin : g_gp
      assign regs[i] = gp_q[i];
    end
  end

  assign rd_addr[0] = rd_a_addr_i;
  assign rd_addr[1] = rd_b_addr_i;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    rf_read_mux #(.NUM_REGS(NUM_REGS)) i_rd_mux (
      .regs_i (regs),
      .addr_i (rd_addr[p]),
      .data_o (rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign acc_o       = acc_q;
  assign status_o    = stat_q;
  assign pc_hi_o     = pch_q[PC_HI_W-1:0];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int NUM_REGS = 64
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [5:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       flag_we_i,
  input logic       flag_zero_i,
  input logic       flag_carry_i,
  input logic [5:0] rd_a_addr_i,
  input logic [7:0] rd_a_data_o,
  input logic [5:0] rd_b_addr_i,
  input logic [7:0] rd_b_data_o,
  input logic [7:0] acc_o,
  input logic [7:0] status_o,
  input logic [3:0] pc_hi_o
);
  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> (acc_o == 8'h00 && status_o == 8'h00 && pc_hi_o == 4'h0));

  a_r2_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i < NUM_REGS) ##1 (rd_a_addr_i == $past(wr_addr_i))
    |-> rd_a_data_o == $past(wr_data_i));

  a_r3_unbuilt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i >= NUM_REGS) |-> rd_a_data_o == 8'h00);

  a_r4_acc_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 6'd0) |=> acc_o == $past(wr_data_i));

  a_r4_acc_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_addr_i == 6'd0) |-> rd_b_data_o == acc_o);

  a_r5_write_over_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 6'd1) |=> status_o == $past(wr_data_i));

  a_r6_flag_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !(wr_en_i && wr_addr_i == 6'd1))
    |=> (status_o[0] == $past(flag_zero_i) && status_o[1] == $past(flag_carry_i)
         && status_o[7:2] == $past(status_o[7:2])));

  a_r7_pch_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == 6'd2) |-> rd_a_data_o[3:0] == pc_hi_o);

  a_r8_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == rd_b_addr_i) |-> rd_a_data_o == rd_b_data_o);

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !flag_we_i) |=> ($stable(acc_o) && $stable(status_o) && $stable(pc_hi_o)));
endmodule

bind banked_regfile rf_checker #(.NUM_REGS(NUM_REGS)) i_rf_checker (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int NREG = 20;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_en, flag_we, flag_z, flag_c;
  logic [5:0] wr_addr, ra, rb;
  logic [7:0] wr_data, rd_a, rd_b, acc, status;
  logic [3:0] pc_hi;

  always #5 clk = ~clk;

  banked_regfile #(.NUM_REGS(NREG)) i_banked_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .flag_we_i(flag_we), .flag_zero_i(flag_z),
    .flag_carry_i(flag_c), .rd_a_addr_i(ra), .rd_a_data_o(rd_a),
    .rd_b_addr_i(rb), .rd_b_data_o(rd_b), .acc_o(acc), .status_o(status),
    .pc_hi_o(pc_hi)
  );

  typedef struct {
    int         src;
    string      tag;
    logic [7:0] exp;
  } item_t;

  item_t      sb_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;
  logic [7:0] mdl [64];
  string      src_name [5] = '{"rd_a", "rd_b", "acc", "status", "pc_hi"};

  function automatic logic [7:0] mdl_rd(int a);
    return (a < NREG) ? mdl[a] : 8'h00;
  endfunction

  task automatic push(int src, string tag, logic [7:0] exp);
    item_t it;
    it.src = src; it.tag = tag; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic push_all(int a, int b, string tag);
    push(0, tag, mdl_rd(a));
    push(1, tag, mdl_rd(b));
    push(2, tag, mdl[0]);
    push(3, tag, mdl[1]);
    push(4, tag, {4'h0, mdl[2][3:0]});
  endtask

  // drive one cycle, queue what the outputs must show before the next edge
  task automatic step(bit we, int wa, logic [7:0] wd, bit fwe, bit fz, bit fc,
                      int a, int b, string tag);
    @(negedge clk); #1;
    wr_en = we; wr_addr = 6'(wa); wr_data = wd;
    flag_we = fwe; flag_z = fz; flag_c = fc;
    ra = 6'(a); rb = 6'(b);
    push_all(a, b, tag);
    if (we && wa < NREG) mdl[wa] = wd;
    if (fwe && !(we && wa == 1)) begin
      mdl[1][0] = fz;
      mdl[1][1] = fc;
    end
  endtask

  task automatic rd(int a, int b, string tag);
    step(0, 0, 8'h00, 0, 0, 0, a, b, tag);
  endtask

  // monitor: compare queued items against the outputs
  initial begin
    forever begin
      @(negedge clk); #3;
      while (sb_q.size() > 0) begin
        item_t      it;
        logic [7:0] act;
        it = sb_q.pop_front();
        case (it.src)
          0:       act = rd_a;
          1:       act = rd_b;
          2:       act = acc;
          3:       act = status;
          default: act = {4'h0, pc_hi};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s: actual=%02h expected=%02h", it.tag, src_name[it.src], act, it.exp);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    rst_ni = 1'b0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    flag_we = 0; flag_z = 0; flag_c = 0; ra = '0; rb = '0;
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;

    // R1: everything zero after reset
    for (int i = 0; i < NREG; i++) rd(i, NREG - 1 - i, "R1");

    // R2: fill GP registers, same-cycle read must show old value
    for (int i = 3; i < NREG; i++) step(1, i, 8'(i * 7 + 3), 0, 0, 0, i, i, "R2");
    // R8: independent ports
    for (int i = 3; i < NREG; i++) rd(i, NREG + 2 - i, "R8");

    // R4: accumulator
    step(1, 0, 8'h5A, 0, 0, 0, 0, 3, "R4");
    rd(0, 0, "R4");

    // R6: flag strobe alone, then with upper status bits set
    step(0, 0, 8'h00, 1, 1, 0, 1, 1, "R6");
    step(1, 1, 8'hF0, 0, 0, 0, 1, 2, "R6");
    step(0, 0, 8'h00, 1, 0, 1, 1, 0, "R6");
    rd(1, 1, "R6");

    // R5: explicit write and strobe in the same cycle
    step(1, 1, 8'h84, 1, 1, 1, 1, 1, "R5");
    rd(1, 1, "R5");
    step(1, 1, 8'h03, 1, 0, 0, 1, 0, "R5");
    rd(1, 2, "R5");

    // R7: program-counter-high
    step(1, 2, 8'hAB, 0, 0, 0, 2, 2, "R7");
    rd(2, 1, "R7");
    step(1, 2, 8'h36, 0, 0, 0, 2, 0, "R7");
    rd(2, 2, "R7");

    // R3: unbuilt addresses
    step(1, 40, 8'hFF, 0, 0, 0, 40, NREG, "R3");
    rd(40, 63, "R3");
    step(1, NREG, 8'hEE, 0, 0, 0, NREG, NREG - 1, "R3");
    for (int i = 0; i < NREG; i++) rd(i, NREG - 1 - i, "R3");

    // R2: highest built address
    step(1, NREG - 1, 8'hC3, 0, 0, 0, NREG - 1, 0, "R2");
    rd(NREG - 1, NREG - 1, "R2");

    // R9: enables low, garbage on address and data
    step(0, 1, 8'h77, 0, 1, 1, 1, 2, "R9");
    step(0, 0, 8'h99, 0, 0, 1, 0, 5, "R9");
    step(0, 2, 8'h11, 0, 1, 0, 2, 7, "R9");
    for (int i = 0; i < NREG; i++) rd(i, i, "R9");

    // R1: asynchronous reset mid-run
    @(negedge clk); #1;
    rst_ni = 1'b0;
    wr_en = 0; flag_we = 0; ra = 6'd3; rb = 6'd0;
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    push_all(3, 0, "R1");
    @(negedge clk); #1 rst_ni = 1'b1;
    for (int i = 0; i < NREG; i++) rd(i, NREG - 1 - i, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule